// File: doc/BRIEF.md
# Translation Cache with Pinned Entries

This block keeps recently used virtual-to-physical page translations so that an address can be translated in the cycle it is presented. It holds two kinds of storage. The first is a main array whose slots are recycled automatically. The second is a small pinned store of four slots. An entry placed in the pinned store stays there until it is released by name. Pinned slots do not count against the main array's capacity.

A combinational lookup port compares a virtual page number against every valid entry in both stores. It returns a hit flag, the physical page number and the attribute bits.

A fill port writes a translation. The caller either lets the block pick a main slot or asks for the translation to be pinned. New main translations go to the slot named by a rotating victim pointer. That pointer starts at slot 0 after reset, so the eviction order is fixed and can be tested.

A maintenance port accepts three commands, and each one acts on the clock edge:
- flush every main entry;
- drop the main entry that matches a given page;
- release one pinned slot by its index.

Top module: `tlb_lockdown`

## Requirements
- R1: After reset no entry is valid: every lookup misses (`lk_hit`=0, `lk_ppn`=0) and `fill_err` is 0.
- R2: A lookup reports hit, physical page and attributes of a matching valid entry, from either store, in the same cycle `lk_vpn` is presented; a page with no valid entry misses.
- R3: A main fill (`fill_lock`=0) of a page not already present writes the slot at the victim pointer. The pointer starts at 0 after reset, steps by one per such fill and wraps after slot MAIN_N-1. The (MAIN_N+1)-th distinct page therefore evicts the first.
- R4: A fill of a page that already has a valid entry overwrites that entry in place. It creates no second copy and does not advance the victim pointer.
- R5: A pinned fill (`fill_lock`=1) of a new page takes the lowest-numbered free pinned slot. Pinned entries survive any number of main fills, and MAIN_N main entries plus four pinned entries can all hit at once.
- R6: A pinned fill of a page not already pinned, while all four pinned slots are valid, raises `fill_err` for exactly the one cycle after the fill and changes no entry.
- R7: `mnt_op`=1 clears every main entry and leaves pinned entries valid.
- R8: `mnt_op`=2 clears only the main entry whose page equals `mnt_vpn`; a pinned entry with that page stays valid.
- R9: `mnt_op`=3 clears the pinned slot numbered `mnt_slot`, and a later pinned fill may reuse that slot.
- R10: A pinned fill of a page currently held in the main array moves it into the pinned store and drops the main copy. At most one entry ever matches a page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_ppn | output | PPN_W | Physical page of the hit (0 on miss) |
| lk_attr | output | ATTR_W | Attributes of the hit (0 on miss) |
| fill_en | input | 1 | Write a translation this cycle |
| fill_lock | input | 1 | Place the translation in the pinned store |
| fill_vpn | input | VPN_W | Page number being written |
| fill_ppn | input | PPN_W | Physical page being written |
| fill_attr | input | ATTR_W | Attributes being written |
| fill_err | output | 1 | Previous pinned fill was refused, store full |
| mnt_op | input | 2 | 0 idle, 1 flush main, 2 drop page, 3 release pinned slot |
| mnt_vpn | input | VPN_W | Page for the drop command |
| mnt_slot | input | 2 | Pinned slot for the release command |

## Verification
The bench first drives the main array past its capacity. It then checks that the oldest page is the one that misses; a design that picked victims in any other order would lose a different page. It then refills a resident page and follows with one new page. If the refill had moved the victim pointer, a different page would be evicted.

With all four pinned slots full, a further pinned fill must be refused and leave no trace. A design that silently evicted a pinned entry, or the main array, would be caught. A released slot must be reused. The last check moves a main entry into the pinned store and then flushes the main array; a design that duplicated the entry or dropped it would be exposed.

// File: rtl/tlb_lockdown.sv
`timescale 1ns/1ps
module tlb_lockdown #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 4,
  parameter int MAIN_N = 16,
  localparam int LOCK_N = 4,
  localparam int MI_W   = $clog2(MAIN_N),
  localparam int LI_W   = $clog2(LOCK_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              fill_en,
  input  logic              fill_lock,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [ATTR_W-1:0] fill_attr,
  output logic              fill_err,
  input  logic [1:0]        mnt_op,
  input  logic [VPN_W-1:0]  mnt_vpn,
  input  logic [LI_W-1:0]   mnt_slot
);
  localparam logic [1:0] OP_FLUSH = 2'd1;
  localparam logic [1:0] OP_DROP  = 2'd2;
  localparam logic [1:0] OP_FREE  = 2'd3;

  logic [MAIN_N-1:0] m_vld;
  logic [VPN_W-1:0]  m_vpn  [MAIN_N];
  logic [PPN_W-1:0]  m_ppn  [MAIN_N];
  logic [ATTR_W-1:0] m_attr [MAIN_N];
  logic [LOCK_N-1:0] l_vld;
  logic [VPN_W-1:0]  l_vpn  [LOCK_N];
  logic [PPN_W-1:0]  l_ppn  [LOCK_N];
  logic [ATTR_W-1:0] l_attr [LOCK_N];
  logic [MI_W-1:0]   rr;

  logic [MAIN_N-1:0] m_hit, f_mhit, d_hit;
  logic [LOCK_N-1:0] l_hit, f_lhit;
  logic [MI_W-1:0]   f_midx;
  logic [LI_W-1:0]   f_lidx, free_idx;
  logic              free_any;

  always_comb begin
    for (int i = 0; i < MAIN_N; i++) begin
      m_hit[i]  = m_vld[i] && (m_vpn[i] == lk_vpn);
      f_mhit[i] = m_vld[i] && (m_vpn[i] == fill_vpn);
      d_hit[i]  = m_vld[i] && (m_vpn[i] == mnt_vpn);
    end
    for (int j = 0; j < LOCK_N; j++) begin
      l_hit[j]  = l_vld[j] && (l_vpn[j] == lk_vpn);
      f_lhit[j] = l_vld[j] && (l_vpn[j] == fill_vpn);
    end
  end

  always_comb begin
    lk_ppn  = '0;
    lk_attr = '0;
    f_midx  = '0;
    f_lidx  = '0;
    for (int i = 0; i < MAIN_N; i++) begin
      if (m_hit[i]) begin
        lk_ppn  = lk_ppn  | m_ppn[i];
        lk_attr = lk_attr | m_attr[i];
      end
      if (f_mhit[i]) f_midx = MI_W'(i);
    end
    for (int j = 0; j < LOCK_N; j++) begin
      if (l_hit[j]) begin
        lk_ppn  = lk_ppn  | l_ppn[j];
        lk_attr = lk_attr | l_attr[j];
      end
      if (f_lhit[j]) f_lidx = LI_W'(j);
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int j = LOCK_N - 1; j >= 0; j--) begin
      if (!l_vld[j]) begin
        free_any = 1'b1;
        free_idx = LI_W'(j);
      end
    end
  end

  assign lk_hit = |m_hit || |l_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_vld    <= '0;
      l_vld    <= '0;
      rr       <= '0;
      fill_err <= 1'b0;
    end else begin
      fill_err <= 1'b0;
      case (mnt_op)
        OP_FLUSH: m_vld <= '0;
        OP_DROP:  m_vld <= m_vld & ~d_hit;
        OP_FREE:  l_vld[mnt_slot] <= 1'b0;
        default: ;
      endcase
      if (fill_en) begin
        if (|f_lhit) begin
          l_ppn[f_lidx]  <= fill_ppn;
          l_attr[f_lidx] <= fill_attr;
        end else if (fill_lock) begin
          if (free_any) begin
            l_vld[free_idx]  <= 1'b1;
            l_vpn[free_idx]  <= fill_vpn;
            l_ppn[free_idx]  <= fill_ppn;
            l_attr[free_idx] <= fill_attr;
            if (|f_mhit) m_vld[f_midx] <= 1'b0;
          end else begin
            fill_err <= 1'b1;
          end
        end else if (|f_mhit) begin
          m_ppn[f_midx]  <= fill_ppn;
          m_attr[f_midx] <= fill_attr;
        end else begin
          m_vld[rr]  <= 1'b1;
          m_vpn[rr]  <= fill_vpn;
          m_ppn[rr]  <= fill_ppn;
          m_attr[rr] <= fill_attr;
          rr <= (rr == MI_W'(MAIN_N - 1)) ? '0 : rr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_lockdown_chk.sv
`timescale 1ns/1ps
module tlb_lockdown_chk #(
  parameter int MAIN_N = 16,
  parameter int LOCK_N = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MAIN_N-1:0] m_hit,
  input logic [LOCK_N-1:0] l_hit,
  input logic [MAIN_N-1:0] m_vld,
  input logic [LOCK_N-1:0] l_vld,
  input logic              fill_en,
  input logic              fill_lock,
  input logic              fill_err,
  input logic [1:0]        mnt_op,
  input logic              lk_hit
);
  // R10
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_hit, l_hit}));
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(fill_en && fill_lock && (&l_vld)));
  // R7
  flush_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mnt_op == 2'd1 && !fill_en) |-> (m_vld == '0));
  // R5
  pin_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!fill_en && mnt_op != 2'd3) |-> (l_vld == $past(l_vld)));
  // R1
  hit_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (|m_vld || |l_vld));
endmodule

bind tlb_lockdown tlb_lockdown_chk #(.MAIN_N(MAIN_N), .LOCK_N(LOCK_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_hit(m_hit), .l_hit(l_hit), .m_vld(m_vld),
  .l_vld(l_vld), .fill_en(fill_en), .fill_lock(fill_lock),
  .fill_err(fill_err), .mnt_op(mnt_op), .lk_hit(lk_hit)
);

// File: tb/tlb_lockdown_bench.sv
`timescale 1ns/1ps
module tlb_lockdown_bench;
  localparam int VW = 12, PW = 12, AW = 4, MN = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0, mnt_vpn = '0;
  logic [PW-1:0] fill_ppn = '0, lk_ppn;
  logic [AW-1:0] fill_attr = '0, lk_attr;
  logic fill_en = 1'b0, fill_lock = 1'b0, lk_hit, fill_err;
  logic [1:0] mnt_op = '0, mnt_slot = '0;
  int errs = 0, checks = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  tlb_lockdown #(.VPN_W(VW), .PPN_W(PW), .ATTR_W(AW), .MAIN_N(MN)) u_tlb_lockdown (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .lk_attr(lk_attr), .fill_en(fill_en), .fill_lock(fill_lock),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_attr(fill_attr),
    .fill_err(fill_err), .mnt_op(mnt_op), .mnt_vpn(mnt_vpn), .mnt_slot(mnt_slot));

  // {kind(0 main fill,1 pinned fill,2 lookup), vpn, ppn, exp bit, exp ppn}
  localparam logic [38:0] VEC [8] = '{
    {2'd0, 12'h010, 12'hA10, 1'b0, 12'h000},
    {2'd0, 12'h020, 12'hA20, 1'b0, 12'h000},
    {2'd2, 12'h010, 12'h000, 1'b1, 12'hA10},
    {2'd2, 12'h030, 12'h000, 1'b0, 12'h000},
    {2'd0, 12'h010, 12'hB10, 1'b0, 12'h000},
    {2'd2, 12'h010, 12'h000, 1'b1, 12'hB10},
    {2'd1, 12'h040, 12'hC40, 1'b0, 12'h000},
    {2'd2, 12'h040, 12'h000, 1'b1, 12'hC40}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input bit lk, input logic [VW-1:0] v, input logic [PW-1:0] p,
                      output bit err);
    @(negedge clk);
    fill_en = 1'b1; fill_lock = lk; fill_vpn = v; fill_ppn = p; fill_attr = p[3:0];
    @(negedge clk);
    err = fill_err;
    fill_en = 1'b0; fill_lock = 1'b0;
  endtask

  task automatic look(input logic [VW-1:0] v, input bit eh, input logic [PW-1:0] ep,
                      input string req);
    lk_vpn = v;
    #1;
    chk(lk_hit == eh && (!eh || lk_ppn == ep) && (!eh || lk_attr == ep[3:0]),
        req, {lk_hit, lk_ppn}, {eh, ep});
  endtask

  task automatic mnt(input logic [1:0] op, input logic [VW-1:0] v, input logic [1:0] s);
    @(negedge clk);
    mnt_op = op; mnt_vpn = v; mnt_slot = s;
    @(negedge clk);
    mnt_op = 2'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit e;
    do_reset();
    // R1 reset state
    look(12'h000, 1'b0, '0, "R1");
    chk(fill_err == 1'b0, "R1", fill_err, 0);
    chk(lk_ppn == '0, "R1", lk_ppn, 0);

    // table: R2 lookups, R4 refill, R5 pinned fill
    for (int k = 0; k < 8; k++) begin
      logic [38:0] w;
      w = VEC[k];
      if (w[38:37] == 2'd2) look(w[36:25], w[12], w[11:0], "R2/R4/R5 table");
      else begin
        fill(w[38:37] == 2'd1, w[36:25], w[24:13], e);
        chk(e == 1'b0, "R3/R5 table fill_err", e, 0);
      end
    end

    // R3 round-robin eviction
    do_reset();
    for (int i = 0; i <= MN; i++) fill(1'b0, 12'h100 + i, 12'h500 + i, e);
    look(12'h100, 1'b0, '0, "R3 oldest evicted");
    for (int i = 1; i <= MN; i++) look(12'h100 + i, 1'b1, 12'h500 + i, "R3 survivors");
    // R4 refill in place, pointer unchanged
    fill(1'b0, 12'h102, 12'h777, e);
    fill(1'b0, 12'h109, 12'h609, e);
    look(12'h101, 1'b0, '0, "R4 pointer not advanced by refill");
    look(12'h102, 1'b1, 12'h777, "R4 refill");
    look(12'h109, 1'b1, 12'h609, "R3 new entry");

    // R5 pinned entries survive and add capacity
    do_reset();
    for (int i = 0; i < 4; i++) fill(1'b1, 12'h200 + i, 12'h820 + i, e);
    for (int i = 0; i < 2 * MN; i++) fill(1'b0, 12'h300 + i, 12'h930 + i, e);
    for (int i = 0; i < 4; i++) look(12'h200 + i, 1'b1, 12'h820 + i, "R5 pinned kept");
    for (int i = MN; i < 2 * MN; i++) look(12'h300 + i, 1'b1, 12'h930 + i, "R5 main full");

    // R6 full pinned store
    fill(1'b1, 12'h204, 12'h844, e);
    chk(e == 1'b1, "R6 err raised", e, 1);
    look(12'h204, 1'b0, '0, "R6 nothing written");
    look(12'h300 + MN, 1'b1, 12'h930 + MN, "R6 main untouched");
    @(negedge clk);
    chk(fill_err == 1'b0, "R6 err one cycle", fill_err, 0);

    // R9 release slot 2 and reuse
    mnt(2'd3, '0, 2'd2);
    look(12'h202, 1'b0, '0, "R9 released");
    look(12'h203, 1'b1, 12'h823, "R9 others kept");
    fill(1'b1, 12'h205, 12'h845, e);
    chk(e == 1'b0, "R9 reuse accepted", e, 0);
    look(12'h205, 1'b1, 12'h845, "R9 reuse");
    fill(1'b1, 12'h206, 12'h846, e);
    chk(e == 1'b1, "R9 slot reused so full again", e, 1);

    // R7 flush main
    mnt(2'd1, '0, 2'd0);
    look(12'h300 + MN, 1'b0, '0, "R7 main cleared");
    look(12'h300 + 2 * MN - 1, 1'b0, '0, "R7 main cleared");
    look(12'h200, 1'b1, 12'h820, "R7 pinned kept");

    // R8 drop one page
    fill(1'b0, 12'h400, 12'hA40, e);
    fill(1'b0, 12'h401, 12'hA41, e);
    mnt(2'd2, 12'h400, 2'd0);
    look(12'h400, 1'b0, '0, "R8 dropped");
    look(12'h401, 1'b1, 12'hA41, "R8 neighbour kept");
    mnt(2'd2, 12'h200, 2'd0);
    look(12'h200, 1'b1, 12'h820, "R8 pinned kept");

    // R10 move main entry into pinned store
    fill(1'b0, 12'h500, 12'h111, e);
    mnt(2'd3, '0, 2'd0);
    fill(1'b1, 12'h500, 12'h222, e);
    chk(e == 1'b0, "R10 move accepted", e, 0);
    look(12'h500, 1'b1, 12'h222, "R10 single copy");
    mnt(2'd1, '0, 2'd0);
    look(12'h500, 1'b1, 12'h222, "R10 now pinned");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule